// File: doc/BRIEF.md
# Periodic Register-Dump Watchdog Monitor

This block supervises a processor under test. A free-running period counter raises a request interrupt to the device under test once per period. The default period is one second of a 200 MHz clock. The device answers with a fixed-length burst of 32-bit register values. Each value arrives on a parallel data port together with a one-cycle valid strobe. The block writes the values, in order, into a local buffer.

When the last value of a burst has been stored, the block raises an interrupt to a host processor. The host reads the buffer through a combinational read port addressed by word index. It then releases the interrupt with an acknowledge pulse.

The block also keeps three counters that saturate instead of wrapping. They count reset pulses seen from the device, requests that were not answered in full within a window, and strobes that arrived when no collection was open. The host can clear all three counters together.

Top module: `dump_monitor`

## Requirements
- R1: While the block is idle, `dev_irq` rises once every `TICK_CYCLES` clock cycles, measured rise to rise.
- R2: `dev_irq` stays high from the request until the cycle after the first valid word is accepted, or until the timeout ends the request.
- R3: The k-th word accepted in a collection (counting from 0) is returned on `host_rd_data` while `host_rd_addr` equals k. Any address of `DUMP_WORDS` or above returns zero.
- R4: The cycle after the `DUMP_WORDS`-th word is accepted, `host_irq` goes high. It stays high until a cycle with `host_ack` high, and is low from the following cycle. `host_irq` and `dev_irq` are never high together.
- R5: If `DUMP_WORDS` words have not been accepted within `TIMEOUT_CYCLES` cycles after the request began, the request ends. `timeout_count` increases by one, `host_irq` is not raised, and the block goes back to waiting for the next period.
- R6: Each cycle with `dev_reset_pulse` high increments `reset_count`. If a collection is open in that cycle, it is aborted: `dev_irq` drops, no timeout is counted and `host_irq` is not raised.
- R7: Each counter stops at its all-ones value of `CNT_W` bits and does not wrap.
- R8: A cycle with `host_clr_cnt` high sets all three counters to zero. This holds even when an event for a counter occurs in the same cycle.
- R9: A strobe on `dev_valid` while no collection is open, either before a request or while `host_irq` is pending, leaves the buffer unchanged and increments `spurious_count`.
- R10: After reset, `dev_irq`, `host_irq`, all counters and every buffer word read back as zero.
- R11: A period that ends while `host_irq` is pending does not raise `dev_irq`. The buffered dump is kept until the host acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq | output | 1 | Request interrupt to the device under test |
| dev_valid | input | 1 | Strobe marking a valid word on `dev_data` |
| dev_data | input | DATA_W | Register value from the device |
| dev_reset_pulse | input | 1 | One cycle per reset event of the device |
| host_irq | output | 1 | Dump-ready interrupt to the host |
| host_ack | input | 1 | Host acknowledge that releases `host_irq` |
| host_rd_addr | input | ADDR_W | Buffer word index read by the host |
| host_rd_data | output | DATA_W | Buffer word at `host_rd_addr` |
| host_clr_cnt | input | 1 | Synchronous clear of all counters |
| reset_count | output | CNT_W | Saturating count of device reset events |
| timeout_count | output | CNT_W | Saturating count of incomplete responses |
| spurious_count | output | CNT_W | Saturating count of strobes outside a collection |

## Verification
The hardest case to reach is a timeout on a collection that is already open. The request has ended, but the full word count has not arrived. The bench reaches it by sending half a dump and then stopping, and it checks that `host_irq` never rises and that the timeout counter moves by exactly one.

A second hard case is a device reset in the middle of a burst. The bench pulses the reset after twenty words and then waits past the timeout window, to confirm that the abort was not also counted as a timeout.

The hold state needs a host that does not answer. The bench leaves a finished dump unacknowledged for longer than one period. During that time it sends a stray strobe and checks that the buffer survives.

// File: rtl/mon_pkg.sv
package mon_pkg;

    // Controller states: waiting for tick, request raised, collecting, host pending
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REQ     = 2'd1,
        ST_COLLECT = 2'd2,
        ST_HOLD    = 2'd3
    } mon_state_t;

    // Event pulses that feed the saturating counters
    typedef struct packed {
        logic spurious;
        logic timeout;
        logic dev_rst;
    } mon_evt_t;

    localparam int NUM_COUNTERS = 3;

    function automatic logic [31:0] sat_step(input logic [31:0] value,
                                             input logic [31:0] limit);
        return (value == limit) ? value : value + 32'd1;
    endfunction

endpackage

// File: rtl/mon_tick_gen.sv
module mon_tick_gen #(
    parameter int TICK_CYCLES = 200_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == CW'(TICK_CYCLES - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == CW'(TICK_CYCLES - 1));
endmodule

// File: rtl/mon_ctrl.sv
module mon_ctrl
    import mon_pkg::*;
#(
    parameter int DUMP_WORDS     = 80,
    parameter int TIMEOUT_CYCLES = 1_000_000,
    parameter int ADDR_W         = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              dev_valid,
    input  logic              dev_reset_pulse,
    input  logic              host_ack,
    output mon_state_t        state,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_idx,
    output mon_evt_t          evt
);
    localparam int WW = $clog2(TIMEOUT_CYCLES);

    mon_state_t        st_q, st_d;
    logic [WW-1:0]     win_q;
    logic [ADDR_W-1:0] idx_q;
    logic              in_window, accept, last_word, expired;

    always_comb begin
        in_window = (st_q == ST_REQ) || (st_q == ST_COLLECT);
        accept    = in_window && dev_valid && !dev_reset_pulse;
        last_word = accept && (idx_q == ADDR_W'(DUMP_WORDS - 1));
        expired   = in_window && !dev_reset_pulse && !last_word &&
                    (win_q == WW'(TIMEOUT_CYCLES - 1));

        evt.dev_rst  = dev_reset_pulse;
        evt.timeout  = expired;
        evt.spurious = dev_valid && !in_window;

        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (tick) st_d = ST_REQ;
            ST_REQ, ST_COLLECT: begin
                if (dev_reset_pulse)  st_d = ST_IDLE;
                else if (last_word)   st_d = ST_HOLD;
                else if (expired)     st_d = ST_IDLE;
                else if (accept)      st_d = ST_COLLECT;
            end
            ST_HOLD: if (host_ack) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            win_q <= '0;
            idx_q <= '0;
        end else begin
            st_q <= st_d;
            if (!in_window) begin
                win_q <= '0;
                idx_q <= '0;
            end else begin
                win_q <= win_q + 1'b1;
                if (accept) idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign state  = st_q;
    assign wr_en  = accept;
    assign wr_idx = idx_q;
endmodule

// File: rtl/mon_buffer.sv
module mon_buffer #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 80,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en && (int'(wr_idx) < DEPTH)) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : '0;
endmodule

// File: rtl/mon_sat_counter.sv
module mon_sat_counter
    import mon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= CNT_W'(sat_step(32'(count), 32'(MAXV)));
        end
    end
endmodule

// File: rtl/dump_monitor.sv
module dump_monitor
    import mon_pkg::*;
#(
    parameter int DATA_W         = 32,
    parameter int DUMP_WORDS     = 80,
    parameter int TICK_CYCLES    = 200_000_000,
    parameter int TIMEOUT_CYCLES = 1_000_000,
    parameter int CNT_W          = 16,
    parameter int ADDR_W         = $clog2(DUMP_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              dev_irq,
    input  logic              dev_valid,
    input  logic [DATA_W-1:0] dev_data,
    input  logic              dev_reset_pulse,
    output logic              host_irq,
    input  logic              host_ack,
    input  logic [ADDR_W-1:0] host_rd_addr,
    output logic [DATA_W-1:0] host_rd_data,
    input  logic              host_clr_cnt,
    output logic [CNT_W-1:0]  reset_count,
    output logic [CNT_W-1:0]  timeout_count,
    output logic [CNT_W-1:0]  spurious_count
);
    logic              tick;
    mon_state_t        st;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_idx;
    mon_evt_t          evt;
    logic [NUM_COUNTERS-1:0] inc_vec;
    logic [CNT_W-1:0]  cnt_arr [NUM_COUNTERS];

    mon_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    mon_ctrl #(
        .DUMP_WORDS(DUMP_WORDS), .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .dev_valid(dev_valid),
        .dev_reset_pulse(dev_reset_pulse), .host_ack(host_ack),
        .state(st), .wr_en(wr_en), .wr_idx(wr_idx), .evt(evt)
    );

    mon_buffer #(.DATA_W(DATA_W), .DEPTH(DUMP_WORDS), .ADDR_W(ADDR_W)) u_buf (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(dev_data),
        .rd_addr(host_rd_addr), .rd_data(host_rd_data)
    );

    assign inc_vec = evt;

    for (genvar g = 0; g < NUM_COUNTERS; g++) begin : g_cnt
        mon_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst(rst), .clr(host_clr_cnt),
            .inc(inc_vec[g]), .count(cnt_arr[g])
        );
    end

    assign reset_count    = cnt_arr[0];
    assign timeout_count  = cnt_arr[1];
    assign spurious_count = cnt_arr[2];
    assign dev_irq        = (st == ST_REQ);
    assign host_irq       = (st == ST_HOLD);
endmodule

// File: rtl/dump_monitor_checker.sv
module dump_monitor_checker
    import mon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             dev_irq,
    input logic             host_irq,
    input logic             dev_valid,
    input logic             dev_reset_pulse,
    input logic             host_ack,
    input logic             host_clr_cnt,
    input logic             timeout_evt,
    input mon_state_t       st,
    input logic [CNT_W-1:0] reset_count,
    input logic [CNT_W-1:0] timeout_count,
    input logic [CNT_W-1:0] spurious_count
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    assert_irq_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(dev_irq && host_irq));

    assert_host_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (host_irq && !host_ack) |=> host_irq);

    assert_host_release_R4: assert property (@(posedge clk) disable iff (rst)
        (host_irq && host_ack) |=> !host_irq);

    assert_dev_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_REQ && !dev_valid && !dev_reset_pulse && !timeout_evt) |=> dev_irq);

    assert_abort_R6: assert property (@(posedge clk) disable iff (rst)
        (dev_irq && dev_reset_pulse) |=> (!dev_irq && !host_irq));

    assert_saturate_R7: assert property (@(posedge clk) disable iff (rst)
        (reset_count == MAXV && !host_clr_cnt) |=> (reset_count == MAXV));

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        host_clr_cnt |=> (reset_count == '0 && timeout_count == '0 && spurious_count == '0));

    assert_spurious_count_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && dev_valid && spurious_count != MAXV && !host_clr_cnt)
        |=> (spurious_count == $past(spurious_count) + 1'b1));

    assert_hold_kept_R11: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && !host_ack) |=> (st == ST_HOLD));
endmodule

bind dump_monitor dump_monitor_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .dev_irq(dev_irq), .host_irq(host_irq),
    .dev_valid(dev_valid), .dev_reset_pulse(dev_reset_pulse), .host_ack(host_ack),
    .host_clr_cnt(host_clr_cnt), .timeout_evt(evt.timeout), .st(st),
    .reset_count(reset_count), .timeout_count(timeout_count),
    .spurious_count(spurious_count)
);

// File: tb/tb_dump_monitor.sv
`timescale 1ns/1ps
module tb_dump_monitor;
    localparam int DATA_W  = 32;
    localparam int WORDS   = 80;
    localparam int TICK    = 600;
    localparam int TMO     = 300;
    localparam int CNT_W   = 3;
    localparam int ADDR_W  = $clog2(WORDS + 1);
    localparam int NVEC    = 4;
    localparam logic [31:0] SEEDS [NVEC] = '{32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_0000, 32'hFFFF_FFFF};
    localparam int          GAPS  [NVEC] = '{0, 1, 2, 0};
    localparam int          DELAY [NVEC] = '{3, 7, 1, 12};

    logic clk = 1'b0, rst = 1'b1;
    logic dev_irq, dev_valid = 1'b0, dev_reset_pulse = 1'b0;
    logic [DATA_W-1:0] dev_data = '0;
    logic host_irq, host_ack = 1'b0, host_clr_cnt = 1'b0;
    logic [ADDR_W-1:0] host_rd_addr = '0;
    logic [DATA_W-1:0] host_rd_data;
    logic [CNT_W-1:0] reset_count, timeout_count, spurious_count;

    int checks = 0, errors = 0;
    longint cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dump_monitor #(
        .DATA_W(DATA_W), .DUMP_WORDS(WORDS), .TICK_CYCLES(TICK),
        .TIMEOUT_CYCLES(TMO), .CNT_W(CNT_W)
    ) dut (
        .clk(clk), .rst(rst), .dev_irq(dev_irq), .dev_valid(dev_valid),
        .dev_data(dev_data), .dev_reset_pulse(dev_reset_pulse), .host_irq(host_irq),
        .host_ack(host_ack), .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
        .host_clr_cnt(host_clr_cnt), .reset_count(reset_count),
        .timeout_count(timeout_count), .spurious_count(spurious_count)
    );

    function automatic logic [31:0] word_of(input logic [31:0] seed, input int i);
        return seed ^ (32'(i) * 32'h9E37_79B1);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_request();
        int guard = 0;
        @(negedge clk);
        while (!dev_irq && guard < 3 * TICK) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic send_words(input logic [31:0] seed, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            dev_valid = 1'b1;
            dev_data  = word_of(seed, i);
            @(negedge clk);
            dev_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic read_compare(input logic [31:0] seed, input string req);
        int bad = 0;
        logic [31:0] first_bad = '0;
        for (int i = 0; i < WORDS; i++) begin
            host_rd_addr = ADDR_W'(i);
            #1;
            if (host_rd_data !== word_of(seed, i)) begin
                if (bad == 0) first_bad = host_rd_data;
                bad++;
            end
            @(negedge clk);
        end
        check(bad == 0, req, first_bad, word_of(seed, 0));
        host_rd_addr = ADDR_W'(WORDS);
        #1;
        check(host_rd_data === '0, "R3 out-of-range address", host_rd_data, 0);
    endtask

    task automatic ack_host();
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        check(host_irq === 1'b0, "R4 host_irq released by ack", 32'(host_irq), 0);
    endtask

    initial begin
        repeat (190_000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        longint prev_rise = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(dev_irq === 1'b0 && host_irq === 1'b0, "R10 irqs after reset", {dev_irq, host_irq}, 0);
        check(reset_count === 0 && timeout_count === 0 && spurious_count === 0,
              "R10 counters after reset", {reset_count, timeout_count, spurious_count}, 0);
        host_rd_addr = '0;
        #1;
        check(host_rd_data === '0, "R10 buffer word 0 after reset", host_rd_data, 0);

        // R9 / R7: strobes before any request, more than the counter can hold
        send_words(32'hAAAA_0000, 10, 0);
        check(spurious_count === 3'd7, "R7 R9 spurious saturates", 32'(spurious_count), 7);
        host_rd_addr = '0;
        #1;
        check(host_rd_data === '0, "R9 idle strobe not stored", host_rd_data, 0);

        // R8: clear wins over a simultaneous event
        host_clr_cnt = 1'b1;
        dev_valid    = 1'b1;
        @(negedge clk);
        host_clr_cnt = 1'b0;
        dev_valid    = 1'b0;
        check(spurious_count === 0, "R8 clear beats increment", 32'(spurious_count), 0);

        // Vector table: full dumps with varied seeds, gaps and first-word delays
        for (int v = 0; v < NVEC; v++) begin
            wait_request();
            if (v > 0)
                check(cyc - prev_rise == TICK, "R1 request period", 32'(cyc - prev_rise), TICK);
            prev_rise = cyc;
            begin
                int dropped = 0;
                for (int d = 0; d < DELAY[v]; d++) begin
                    if (!dev_irq) dropped++;
                    @(negedge clk);
                end
                check(dropped == 0 && dev_irq === 1'b1, "R2 request held before first word", 32'(dropped), 0);
            end
            send_words(SEEDS[v], 1, GAPS[v]);
            check(dev_irq === 1'b0, "R2 request drops after first word", 32'(dev_irq), 0);
            send_words(SEEDS[v] ^ 32'h0, 0, 0);
            for (int i = 1; i < WORDS; i++) begin
                dev_valid = 1'b1;
                dev_data  = word_of(SEEDS[v], i);
                @(negedge clk);
                dev_valid = 1'b0;
                repeat (GAPS[v]) @(negedge clk);
            end
            check(host_irq === 1'b1, "R4 host_irq after last word", 32'(host_irq), 1);
            repeat (10) @(negedge clk);
            check(host_irq === 1'b1, "R4 host_irq held without ack", 32'(host_irq), 1);
            read_compare(SEEDS[v], "R3 buffer contents");
            ack_host();
            check(timeout_count === 0, "R5 no timeout on complete dump", 32'(timeout_count), 0);
        end

        // R9 during hold, R11 tick dropped while host pending
        wait_request();
        send_words(32'h5555_0000, WORDS, 0);
        check(host_irq === 1'b1, "R4 host_irq for hold test", 32'(host_irq), 1);
        dev_valid = 1'b1;
        dev_data  = 32'hBAD0_BAD0;
        @(negedge clk);
        dev_valid = 1'b0;
        check(spurious_count === 1, "R9 strobe during hold counted", 32'(spurious_count), 1);
        host_rd_addr = '0;
        #1;
        check(host_rd_data === word_of(32'h5555_0000, 0), "R9 strobe during hold not stored",
              host_rd_data, word_of(32'h5555_0000, 0));
        begin
            int rises = 0;
            for (int c = 0; c < TICK + 50; c++) begin
                @(negedge clk);
                if (dev_irq) rises++;
            end
            check(rises == 0 && host_irq === 1'b1, "R11 no request while host pending", 32'(rises), 0);
        end
        read_compare(32'h5555_0000, "R11 dump kept while pending");
        ack_host();

        // R5 + R2: no response at all
        wait_request();
        repeat (TMO - 1) @(negedge clk);
        check(dev_irq === 1'b1, "R2 request held until timeout", 32'(dev_irq), 1);
        @(negedge clk);
        check(dev_irq === 1'b0, "R5 request ends at timeout", 32'(dev_irq), 0);
        check(timeout_count === 1, "R5 timeout counted once", 32'(timeout_count), 1);
        check(host_irq === 1'b0, "R5 no host_irq on timeout", 32'(host_irq), 0);

        // R5: partial dump
        wait_request();
        send_words(32'h7777_0000, WORDS / 2, 0);
        begin
            int hi = 0;
            for (int c = 0; c < TMO; c++) begin
                @(negedge clk);
                if (host_irq) hi++;
            end
            check(hi == 0, "R5 partial dump raises no host_irq", 32'(hi), 0);
        end
        check(timeout_count === 2, "R5 partial dump counted as timeout", 32'(timeout_count), 2);

        // R6: device reset mid-dump
        wait_request();
        send_words(32'h9999_0000, 20, 0);
        dev_reset_pulse = 1'b1;
        @(negedge clk);
        dev_reset_pulse = 1'b0;
        check(reset_count === 1, "R6 reset counted", 32'(reset_count), 1);
        begin
            int hi = 0;
            for (int c = 0; c < TMO + 10; c++) begin
                @(negedge clk);
                if (host_irq) hi++;
            end
            check(hi == 0, "R6 aborted dump raises no host_irq", 32'(hi), 0);
        end
        check(timeout_count === 2, "R6 abort not counted as timeout", 32'(timeout_count), 2);
        dev_reset_pulse = 1'b1;
        @(negedge clk);
        dev_reset_pulse = 1'b0;
        check(reset_count === 2, "R6 idle reset counted", 32'(reset_count), 2);

        // R8: clear everything
        host_clr_cnt = 1'b1;
        @(negedge clk);
        host_clr_cnt = 1'b0;
        check(reset_count === 0 && timeout_count === 0 && spurious_count === 0,
              "R8 all counters cleared", {reset_count, timeout_count, spurious_count}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule